// File: doc/BRIEF.md
# Aligned Power-of-Two Vector Allocator

This block hands out and takes back blocks of interrupt vectors. It keeps one occupancy bitmap for each of a fixed set of frames. Each frame has a base vector number and a vector count, and both are set at elaboration time. A requester asks for a number of contiguous vectors. The allocator rounds that number up to a power of two and searches for a free region of that size whose offset is a multiple of the size. It marks the region as used and returns the frame index and the absolute vector number.

A release request names the frame, the absolute vector and the original count. The allocator turns the vector back into a frame offset and checks the region. When the whole region is owned, it clears the region.

Requests use a valid/busy handshake. A request is taken only while `busy` is low. `busy` stays high while the search or the release runs. The result comes back as a one-cycle `rsp_valid` pulse, after which the block is ready again. The search tests one aligned candidate region per clock. It walks the frames in index order, and within a frame it walks offsets upward.

Top module: `vec_alloc_top`

## Requirements
- R1: A request for N vectors (1 to 32) takes a region of 2^ceil(log2 N) vectors. N=3 takes 4 vectors and N=17 takes 32.
- R2: The frame offset of a granted region (vector minus frame base) is a multiple of the rounded region size.
- R3: The search tries frame 0 first, then the higher indices in order. Within a frame it tries offsets from low to high. The first region whose bits are all free is granted.
- R4: When no frame has a fitting free region, the response has `rsp_ok`=0 and `rsp_err`=0, and no bitmap bit changes.
- R5: A grant returns `rsp_ok`=1, the chosen frame in `rsp_frame`, and the frame base plus the region offset in `rsp_vector`. A region never reaches past the frame's vector count.
- R6: A release subtracts the frame base from the given vector and clears the rounded, aligned region, so later requests can be granted that region again. A successful release answers `rsp_ok`=1 and `rsp_err`=0.
- R7: A release is refused with `rsp_ok`=0 and `rsp_err`=1, and with the bitmap unchanged, in any of these cases: the vector is below the frame base, the offset is not aligned to the rounded size, the region extends past the frame count, or any bit in the region is not allocated.
- R8: A request with count 0 or count above 32 is refused in the cycle after acceptance. For an allocation the refusal has `rsp_err`=0, and for a release it has `rsp_err`=1.
- R9: `busy` rises in the cycle after a request is accepted and stays high until the response. Requests presented while `busy` is high are ignored. `rsp_valid` lasts exactly one cycle and only occurs while `busy` is high.
- R10: After reset, `busy` and `rsp_valid` are low and every vector of every frame is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_free | input | 1 | 0 = allocate, 1 = release |
| req_count | input | 6 | Number of vectors requested or released |
| req_frame | input | FW | Frame index for a release |
| req_vector | input | 10 | Absolute vector number for a release |
| busy | output | 1 | Block is working on a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ok | output | 1 | Grant or successful release |
| rsp_err | output | 1 | Release refused |
| rsp_frame | output | FW | Frame of the granted or released region |
| rsp_vector | output | 10 | Absolute first vector of the region |

## Verification
Two situations are hard to reach from the ports. The first is a search that must move past an occupied frame into the next one. The second is a request that arrives while a long search is still running. The stimulus fills the low offsets of frame 0 with small requests. A 32-vector request then finds every aligned slot in frame 0 taken or too long, and has to spill into frame 1. During that scan, while `busy` is high, the bench presents a release of a live region. A later allocation then shows whether that region is still held. A long pseudo-random phase mixes grants, releases and out-of-range counts against a bitmap model kept in the bench.

// File: rtl/vec_alloc_pkg.sv
package vec_alloc_pkg;

    // absolute vector number width (vectors 0..1023)
    localparam int VEC_W     = 10;
    // offset arithmetic width: one bit wider than a vector
    localparam int OFF_W     = VEC_W + 1;
    // request count width: wide enough to express 0..63
    localparam int CNT_W     = 6;
    // largest region is 2^MAX_ORDER vectors
    localparam int MAX_ORDER = 5;
    localparam int MAX_REQ   = 1 << MAX_ORDER;
    localparam int ORD_W     = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_FREE = 2'd2,
        ST_RESP = 2'd3
    } alloc_state_e;

    typedef enum logic {
        OP_ALLOC = 1'b0,
        OP_FREE  = 1'b1
    } alloc_op_e;

    typedef struct packed {
        logic             ok;
        logic             err;
        logic [VEC_W-1:0] vector;
    } alloc_rsp_t;

    // smallest order k with 2^k >= n (n assumed 1..MAX_REQ)
    function automatic logic [ORD_W-1:0] round_order(input logic [CNT_W-1:0] n);
        logic [ORD_W-1:0] o;
        logic [CNT_W:0]   p;
        o = ORD_W'(MAX_ORDER);
        for (int k = MAX_ORDER; k >= 0; k--) begin
            p = (CNT_W+1)'(1) << k;
            if (p >= {1'b0, n}) o = ORD_W'(k);
        end
        return o;
    endfunction

    function automatic logic count_legal(input logic [CNT_W-1:0] n);
        return (n != '0) && (n <= CNT_W'(MAX_REQ));
    endfunction

endpackage

// File: rtl/vec_frame_cfg.sv
module vec_frame_cfg
    import vec_alloc_pkg::*;
#(
    parameter int                          NUM_FRAMES = 2,
    parameter int                          FW         = 1,
    parameter logic [NUM_FRAMES*VEC_W-1:0] BASES      = '0,
    parameter logic [NUM_FRAMES*OFF_W-1:0] LIMITS     = '0
) (
    input  logic [FW-1:0]    sel,
    output logic [VEC_W-1:0] base,
    output logic [OFF_W-1:0] limit
);

    // an index with no frame behind it reads as an empty frame
    always_comb begin
        base  = '0;
        limit = '0;
        for (int f = 0; f < NUM_FRAMES; f++) begin
            if (sel == FW'(f)) begin
                base  = BASES[f*VEC_W +: VEC_W];
                limit = LIMITS[f*OFF_W +: OFF_W];
            end
        end
    end

endmodule

// File: rtl/vec_region_mask.sv
module vec_region_mask
    import vec_alloc_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic [OFF_W-1:0] off,
    input  logic [ORD_W-1:0] ord,
    output logic [DEPTH-1:0] mask,
    output logic [OFF_W-1:0] size
);

    logic [OFF_W-1:0] stop;

    assign size = OFF_W'(1) << ord;
    assign stop = off + size;

    for (genvar i = 0; i < DEPTH; i++) begin : g_bit
        assign mask[i] = (OFF_W'(i) >= off) && (OFF_W'(i) < stop);
    end

endmodule

// File: rtl/vec_frame_map.sv
module vec_frame_map
    import vec_alloc_pkg::*;
#(
    parameter int NUM_FRAMES = 2,
    parameter int DEPTH      = 64,
    parameter int FW         = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [FW-1:0]    sel_frame,
    input  logic [DEPTH-1:0] mask,
    input  logic             wr_en,
    input  logic             wr_set,
    output logic             all_free,
    output logic             all_used
);

    logic [NUM_FRAMES-1:0][DEPTH-1:0] frame_bits;
    logic [DEPTH-1:0]                 sel_bits;
    logic [DEPTH-1:0]                 hit;

    for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
        logic [DEPTH-1:0] bits_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bits_q <= '0;
            end else if (wr_en && (sel_frame == FW'(f))) begin
                if (wr_set) bits_q <= bits_q | mask;
                else        bits_q <= bits_q & ~mask;
            end
        end
        assign frame_bits[f] = bits_q;
    end

    always_comb begin
        sel_bits = '0;
        for (int f = 0; f < NUM_FRAMES; f++) begin
            if (sel_frame == FW'(f)) sel_bits = frame_bits[f];
        end
    end

    assign hit      = sel_bits & mask;
    assign all_free = (hit == '0);
    assign all_used = (hit == mask);

endmodule

// File: rtl/vec_alloc_top.sv
module vec_alloc_top
    import vec_alloc_pkg::*;
#(
    parameter int                          NUM_FRAMES   = 2,
    parameter int                          DEPTH        = 64,
    parameter logic [NUM_FRAMES*VEC_W-1:0] FRAME_BASES  = {10'd100, 10'd32},
    parameter logic [NUM_FRAMES*OFF_W-1:0] FRAME_LIMITS = {11'd64, 11'd40},
    localparam int                         FW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_free,
    input  logic [CNT_W-1:0] req_count,
    input  logic [FW-1:0]    req_frame,
    input  logic [VEC_W-1:0] req_vector,
    output logic             busy,
    output logic             rsp_valid,
    output logic             rsp_ok,
    output logic             rsp_err,
    output logic [FW-1:0]    rsp_frame,
    output logic [VEC_W-1:0] rsp_vector
);

    alloc_state_e     state_q;
    alloc_op_e        op_q;
    logic [ORD_W-1:0] ord_q;
    logic [FW-1:0]    frame_q;
    logic [OFF_W-1:0] off_q;
    logic [VEC_W-1:0] vec_q;
    alloc_rsp_t       rsp_q;
    logic [FW-1:0]    rsp_frame_q;

    // selected frame configuration
    logic [VEC_W-1:0] cfg_base;
    logic [OFF_W-1:0] cfg_limit;

    // region under test
    logic [OFF_W-1:0] reg_off;
    logic [OFF_W-1:0] reg_size;
    logic [DEPTH-1:0] reg_mask;
    logic             map_free;
    logic             map_used;
    logic             map_wr;
    logic             map_set;

    // release decode
    logic [OFF_W-1:0] rel_off;
    logic             rel_above;
    logic             rel_align;
    logic             rel_fit;
    logic             rel_ok;

    // scan decode
    logic             cand_fit;
    logic             cand_take;
    logic             last_frame;

    vec_frame_cfg #(
        .NUM_FRAMES (NUM_FRAMES),
        .FW         (FW),
        .BASES      (FRAME_BASES),
        .LIMITS     (FRAME_LIMITS)
    ) u_cfg (
        .sel   (frame_q),
        .base  (cfg_base),
        .limit (cfg_limit)
    );

    vec_region_mask #(
        .DEPTH (DEPTH)
    ) u_mask (
        .off  (reg_off),
        .ord  (ord_q),
        .mask (reg_mask),
        .size (reg_size)
    );

    vec_frame_map #(
        .NUM_FRAMES (NUM_FRAMES),
        .DEPTH      (DEPTH),
        .FW         (FW)
    ) u_map (
        .clk       (clk),
        .rst       (rst),
        .sel_frame (frame_q),
        .mask      (reg_mask),
        .wr_en     (map_wr),
        .wr_set    (map_set),
        .all_free  (map_free),
        .all_used  (map_used)
    );

    // release: vector back to frame offset
    assign rel_off   = {1'b0, vec_q} - {1'b0, cfg_base};
    assign rel_above = (vec_q >= cfg_base);
    assign rel_align = ((rel_off & (reg_size - OFF_W'(1))) == '0);
    assign rel_fit   = ((rel_off + reg_size) <= cfg_limit);
    assign rel_ok    = rel_above && rel_align && rel_fit && map_used;

    // scan: one aligned candidate per clock
    assign cand_fit   = ((off_q + reg_size) <= cfg_limit);
    assign cand_take  = cand_fit && map_free;
    assign last_frame = (frame_q == FW'(NUM_FRAMES - 1));

    assign reg_off = (state_q == ST_FREE) ? rel_off : off_q;

    assign map_wr  = ((state_q == ST_SCAN) && cand_take) ||
                     ((state_q == ST_FREE) && rel_ok);
    assign map_set = (state_q == ST_SCAN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            op_q        <= OP_ALLOC;
            ord_q       <= '0;
            frame_q     <= '0;
            off_q       <= '0;
            vec_q       <= '0;
            rsp_q       <= '0;
            rsp_frame_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q    <= req_free ? OP_FREE : OP_ALLOC;
                        ord_q   <= round_order(req_count);
                        frame_q <= req_free ? req_frame : '0;
                        off_q   <= '0;
                        vec_q   <= req_vector;
                        if (!count_legal(req_count)) begin
                            rsp_q.ok     <= 1'b0;
                            rsp_q.err    <= req_free;
                            rsp_q.vector <= '0;
                            rsp_frame_q  <= '0;
                            state_q      <= ST_RESP;
                        end else begin
                            state_q <= req_free ? ST_FREE : ST_SCAN;
                        end
                    end
                end
                ST_SCAN: begin
                    if (cand_take) begin
                        rsp_q.ok     <= 1'b1;
                        rsp_q.err    <= 1'b0;
                        rsp_q.vector <= cfg_base + off_q[VEC_W-1:0];
                        rsp_frame_q  <= frame_q;
                        state_q      <= ST_RESP;
                    end else if (cand_fit) begin
                        off_q <= off_q + reg_size;
                    end else if (last_frame) begin
                        rsp_q.ok     <= 1'b0;
                        rsp_q.err    <= 1'b0;
                        rsp_q.vector <= '0;
                        rsp_frame_q  <= '0;
                        state_q      <= ST_RESP;
                    end else begin
                        frame_q <= frame_q + FW'(1);
                        off_q   <= '0;
                    end
                end
                ST_FREE: begin
                    rsp_q.ok     <= rel_ok;
                    rsp_q.err    <= !rel_ok;
                    rsp_q.vector <= rel_ok ? vec_q : '0;
                    rsp_frame_q  <= rel_ok ? frame_q : '0;
                    state_q      <= ST_RESP;
                end
                ST_RESP: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign rsp_valid  = (state_q == ST_RESP);
    assign rsp_ok     = rsp_q.ok;
    assign rsp_err    = rsp_q.err;
    assign rsp_frame  = rsp_frame_q;
    assign rsp_vector = rsp_q.vector;

endmodule

// File: rtl/vec_alloc_chk.sv
module vec_alloc_chk
    import vec_alloc_pkg::*;
#(
    parameter int                          NUM_FRAMES   = 2,
    parameter int                          FW           = 1,
    parameter logic [NUM_FRAMES*VEC_W-1:0] FRAME_BASES  = '0,
    parameter logic [NUM_FRAMES*OFF_W-1:0] FRAME_LIMITS = '0
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_free,
    input logic [CNT_W-1:0] req_count,
    input logic             busy,
    input logic             rsp_valid,
    input logic             rsp_ok,
    input logic             rsp_err,
    input logic [FW-1:0]    rsp_frame,
    input logic [VEC_W-1:0] rsp_vector
);

    logic             c_free;
    logic [ORD_W-1:0] c_ord;
    logic [VEC_W-1:0] g_base;
    logic [OFF_W-1:0] g_limit;
    logic [OFF_W-1:0] g_size;
    logic [OFF_W-1:0] g_off;
    logic             accept;
    logic             bad_count;

    assign accept    = req_valid && !busy;
    assign bad_count = (req_count == '0) || (req_count > CNT_W'(MAX_REQ));

    always_ff @(posedge clk) begin
        if (rst) begin
            c_free <= 1'b0;
            c_ord  <= '0;
        end else if (accept) begin
            c_free <= req_free;
            c_ord  <= round_order(req_count);
        end
    end

    always_comb begin
        g_base  = '0;
        g_limit = '0;
        for (int f = 0; f < NUM_FRAMES; f++) begin
            if (rsp_frame == FW'(f)) begin
                g_base  = FRAME_BASES[f*VEC_W +: VEC_W];
                g_limit = FRAME_LIMITS[f*OFF_W +: OFF_W];
            end
        end
    end

    assign g_size = OFF_W'(1) << c_ord;
    assign g_off  = {1'b0, rsp_vector} - {1'b0, g_base};

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);  // R9

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);  // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !rsp_valid);  // R9

    AST_BAD_COUNT_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (accept && bad_count) |=> (rsp_valid && !rsp_ok));  // R8

    AST_GRANT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ok && !c_free) |-> ((g_off & (g_size - OFF_W'(1))) == '0));  // R2

    AST_GRANT_INSIDE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ok && !c_free) |-> ((rsp_vector >= g_base) && ((g_off + g_size) <= g_limit)));  // R5

    AST_ALLOC_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !c_free) |-> !rsp_err);  // R4

    AST_OK_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !(rsp_ok && rsp_err));  // R7

endmodule

bind vec_alloc_top vec_alloc_chk #(
    .NUM_FRAMES   (NUM_FRAMES),
    .FW           (FW),
    .FRAME_BASES  (FRAME_BASES),
    .FRAME_LIMITS (FRAME_LIMITS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_free   (req_free),
    .req_count  (req_count),
    .busy       (busy),
    .rsp_valid  (rsp_valid),
    .rsp_ok     (rsp_ok),
    .rsp_err    (rsp_err),
    .rsp_frame  (rsp_frame),
    .rsp_vector (rsp_vector)
);

// File: tb/sim_vec_alloc_top.sv
module sim_vec_alloc_top;
    import vec_alloc_pkg::*;

    localparam int NF    = 2;
    localparam int DEPTH = 64;
    localparam int BASE [NF] = '{32, 100};
    localparam int LIM  [NF] = '{40, 64};

    logic             clk;
    logic             rst;
    logic             req_valid;
    logic             req_free;
    logic [CNT_W-1:0] req_count;
    logic [0:0]       req_frame;
    logic [VEC_W-1:0] req_vector;
    logic             busy;
    logic             rsp_valid;
    logic             rsp_ok;
    logic             rsp_err;
    logic [0:0]       rsp_frame;
    logic [VEC_W-1:0] rsp_vector;

    vec_alloc_top #(
        .NUM_FRAMES   (NF),
        .DEPTH        (DEPTH),
        .FRAME_BASES  ({10'd100, 10'd32}),
        .FRAME_LIMITS ({11'd64, 11'd40})
    ) u0 (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_free   (req_free),
        .req_count  (req_count),
        .req_frame  (req_frame),
        .req_vector (req_vector),
        .busy       (busy),
        .rsp_valid  (rsp_valid),
        .rsp_ok     (rsp_ok),
        .rsp_err    (rsp_err),
        .rsp_frame  (rsp_frame),
        .rsp_vector (rsp_vector)
    );

    typedef struct {
        bit    ok;
        bit    err;
        int    frame;
        int    vec;
        string tag;
    } exp_t;

    typedef struct {
        int f;
        int v;
        int n;
    } own_t;

    exp_t exp_q[$];
    own_t own_q[$];
    bit   map_m [NF][DEPTH];
    int   checks;
    int   fails;
    bit   done;

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic int rsize(int n);
        int s = 1;
        while (s < n) s = s * 2;
        return s;
    endfunction

    task automatic check(bit cond, string tag, string what, int act, int expv);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    function automatic exp_t m_alloc(int n);
        exp_t e;
        int   s;
        bit   clear;
        e.ok = 0; e.err = 0; e.frame = 0; e.vec = 0; e.tag = "";
        if (n < 1 || n > 32) return e;
        s = rsize(n);
        for (int f = 0; f < NF; f++) begin
            for (int off = 0; off + s <= LIM[f]; off += s) begin
                clear = 1;
                for (int b = off; b < off + s; b++) if (map_m[f][b]) clear = 0;
                if (clear) begin
                    for (int b = off; b < off + s; b++) map_m[f][b] = 1;
                    e.ok = 1; e.frame = f; e.vec = BASE[f] + off;
                    return e;
                end
            end
        end
        return e;
    endfunction

    function automatic exp_t m_free(int f, int v, int n);
        exp_t e;
        int   s;
        int   d;
        e.ok = 0; e.err = 1; e.frame = 0; e.vec = 0; e.tag = "";
        if (n < 1 || n > 32) return e;
        if (f < 0 || f >= NF) return e;
        if (v < BASE[f]) return e;
        s = rsize(n);
        d = v - BASE[f];
        if ((d % s) != 0) return e;
        if (d + s > LIM[f]) return e;
        for (int b = d; b < d + s; b++) if (!map_m[f][b]) return e;
        for (int b = d; b < d + s; b++) map_m[f][b] = 0;
        e.ok = 1; e.err = 0; e.frame = f; e.vec = v;
        return e;
    endfunction

    // driver: predicts, queues, presents one request, waits for its response
    task automatic drive(bit fr, int n, int f, int v, string tag, output exp_t e);
        if (fr) e = m_free(f, v, n);
        else    e = m_alloc(n);
        e.tag = tag;
        exp_q.push_back(e);
        while (busy) @(negedge clk);
        req_valid  = 1'b1;
        req_free   = fr;
        req_count  = CNT_W'(n);
        req_frame  = 1'(f);
        req_vector = VEC_W'(v);
        @(negedge clk);
        req_valid = 1'b0;
        if (n < 1 || n > 32)
            check(rsp_valid === 1'b1, "R8", "immediate refusal strobe", int'(rsp_valid), 1);
        else
            check(busy === 1'b1, "R9", "busy after accept", int'(busy), 1);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // monitor: pops the oldest prediction on every response
    always @(negedge clk) begin : monitor
        exp_t e;
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", "response with nothing outstanding", 1, 0);
            end else begin
                e = exp_q.pop_front();
                check(rsp_ok == e.ok, e.tag, "rsp_ok", int'(rsp_ok), int'(e.ok));
                check(rsp_err == e.err, e.tag, "rsp_err", int'(rsp_err), int'(e.err));
                if (e.ok) begin
                    check(int'(rsp_frame) == e.frame, e.tag, "rsp_frame", int'(rsp_frame), e.frame);
                    check(int'(rsp_vector) == e.vec, e.tag, "rsp_vector", int'(rsp_vector), e.vec);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog: actual 0 expected 1 (run finished)");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        exp_t e;
        exp_t ei;
        logic [15:0] lfsr;
        checks = 0; fails = 0; done = 0;
        for (int f = 0; f < NF; f++) for (int b = 0; b < DEPTH; b++) map_m[f][b] = 0;
        rst = 1'b1; req_valid = 1'b0; req_free = 1'b0;
        req_count = '0; req_frame = '0; req_vector = '0;
        repeat (4) @(negedge clk);
        check(busy === 1'b0, "R10", "busy in reset", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy === 1'b0, "R10", "busy after reset", int'(busy), 0);
        check(rsp_valid === 1'b0, "R10", "rsp_valid after reset", int'(rsp_valid), 0);

        // fill low offsets of frame 0
        drive(0, 1, 0, 0, "R10 R5 first grant at frame 0 base", e);
        check(e.vec == 32, "R5", "model first vector", e.vec, 32);
        drive(0, 3, 0, 0, "R1 R2 count 3 takes aligned 4", e);
        drive(0, 1, 0, 0, "R3 lowest free offset", e);
        drive(0, 5, 0, 0, "R1 R2 count 5 takes aligned 8", e);
        drive(0, 32, 0, 0, "R3 R5 spill into frame 1", e);
        check(e.frame == 1 && e.vec == 100, "R3", "model spill vector", e.vec, 100);

        // request presented mid-scan must be ignored
        ei = m_alloc(32);
        ei.tag = "R9 R3 scan with intrusion";
        exp_q.push_back(ei);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_free = 1'b0; req_count = CNT_W'(32);
        @(negedge clk);
        check(busy === 1'b1, "R9", "busy during scan", int'(busy), 1);
        req_free = 1'b1; req_count = CNT_W'(4); req_frame = 1'b0; req_vector = VEC_W'(36);
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(busy === 1'b0, "R9", "idle after ignored request", int'(busy), 0);

        drive(0, 32, 0, 0, "R4 no space anywhere", e);
        drive(0, 4, 0, 0, "R4 R9 bitmap kept after refusal and ignored release", e);
        check(e.vec == 48, "R9", "model vector after intrusion", e.vec, 48);
        drive(0, 0, 0, 0, "R8 count zero", e);
        drive(0, 33, 0, 0, "R8 count 33", e);
        drive(1, 0, 0, 32, "R8 release with count zero", e);

        drive(1, 32, 1, 100, "R6 release 32 in frame 1", e);
        drive(0, 17, 0, 0, "R6 R1 reuse released region", e);
        check(e.vec == 100, "R6", "model reuse vector", e.vec, 100);
        drive(1, 1, 0, 32, "R6 release single", e);
        drive(1, 1, 0, 32, "R7 double release", e);
        drive(1, 4, 0, 34, "R7 misaligned release", e);
        drive(1, 1, 1, 99, "R7 below frame base", e);
        drive(1, 32, 0, 64, "R7 past frame count", e);
        drive(0, 2, 0, 0, "R7 R6 bitmap intact after refused releases", e);

        // pseudo-random mix
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[0] && own_q.size() > 0) begin
                int   idx;
                own_t o;
                idx = int'(lfsr[11:4]) % own_q.size();
                o = own_q[idx];
                own_q.delete(idx);
                drive(1, o.n, o.f, o.v, "R6 R7 random release", e);
            end else begin
                int n;
                n = int'(lfsr[15:9]) % 34;
                drive(0, n, 0, 0, "R1 R3 R4 R8 random allocate", e);
                if (e.ok) own_q.push_back('{f: e.frame, v: e.vec, n: n});
            end
        end

        repeat (4) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule